// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words and reports whether the first is greater than, less than or equal to the second. It is built from 4-bit comparator slices. Each slice also takes a three-wire result from a less significant slice, so a wider comparison is made by chaining slices in series with no glue logic. The words may hold plain binary, BCD or any other monotonic code. The block treats them as unsigned weighted values.

The top level chains `SLICES` slices. Slice 0 holds the least significant nibble and takes the external cascade inputs. Each slice passes its three results to the cascade inputs of the next more significant slice. The most significant slice drives the final outputs. To compare a standalone word pair, tie the external cascade inputs to greater=0, less=0, equal=1.

Every combination of cascade inputs has a defined result, including the ones that are not legal. The block has no clock and no storage, so every output is a pure function of the present inputs.

Top module: `cmp_chain`

## Requirements
- R1: Within a slice, bit 3 carries the most weight. The first unequal bit pair, scanning from bit 3 toward bit 0, decides the result. If that pair has the A bit set, the slice outputs greater=1, less=0, equal=0. Otherwise it outputs greater=0, less=1, equal=0.
- R2: When the two nibbles of a slice differ, the slice's cascade inputs have no effect on its outputs.
- R3: When the nibbles are equal and cascade-equal is 1, the slice outputs greater=0, less=0, equal=1, whatever the other two cascade inputs hold.
- R4: When the nibbles are equal, cascade-equal is 0 and exactly one of cascade-greater and cascade-less is 1, the slice copies the three cascade inputs to its outputs.
- R5: When the nibbles are equal, cascade-equal is 0 and cascade-greater and cascade-less are both 1, the slice drives all three outputs to 0.
- R6: When the nibbles are equal and all three cascade inputs are 0, the slice outputs greater=1, less=1, equal=0.
- R7: Slice k (k counted from 0) compares bits 4k+3 down to 4k. Its outputs feed the cascade inputs of slice k+1, and the outputs of slice SLICES-1 are the block outputs. With the cascade inputs tied to 0,0,1, the outputs give the unsigned comparison of the full 4·SLICES-bit words.
- R8: The outputs depend only on the present inputs. They reach their final value without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*SLICES | First operand; the most significant slice holds the top nibble |
| b_i | input | 4*SLICES | Second operand |
| casc_gt_i | input | 1 | Greater result carried in from a less significant stage |
| casc_lt_i | input | 1 | Less result carried in from a less significant stage |
| casc_eq_i | input | 1 | Equal result carried in from a less significant stage |
| gt_o | output | 1 | A is greater than B |
| lt_o | output | 1 | A is less than B |
| eq_o | output | 1 | A equals B |

## Verification
The hardest case to reach from the ports is an illegal cascade pattern travelling through a chain. Every nibble must match for the pattern to pass through the slices. Each slice then flips the pattern between all-low and greater-and-less-high, so the final value depends on the parity of the chain length. Random wide operands almost never produce equal words. The bench therefore builds equal pairs on purpose, and pairs that differ in only one chosen nibble, and applies all eight cascade patterns to each. A one-slice instance gets an exhaustive sweep of every nibble pair and every cascade pattern.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int NIB_W = 4;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } cmp_res_t;
endpackage

// File: rtl/cmp_word_order.sv
// Scans a word from the MSB down; reports whether any pair differs and,
// if so, whether A holds the set bit at the first differing position.
module cmp_word_order #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         differ_o,
  output logic         a_above_o
);
  logic still_same;
  logic a_wins;

  always_comb begin
    still_same = 1'b1;
    a_wins     = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (still_same && (a_i[i] != b_i[i])) begin
        a_wins     = a_i[i];
        still_same = 1'b0;
      end
    end
  end

  assign differ_o  = ~still_same;
  assign a_above_o = a_wins;
endmodule

// File: rtl/cmp_cascade_merge.sv
// Combines the local order with the incoming cascade result using the
// fixed priority: local difference first, then cascade-equal, then the rest.
module cmp_cascade_merge
  import cmp_pkg::*;
(
  input  logic     differ_i,
  input  logic     a_above_i,
  input  cmp_res_t carry_i,
  output cmp_res_t res_o
);
  always_comb begin
    if (differ_i) begin
      res_o.gt = a_above_i;
      res_o.lt = ~a_above_i;
      res_o.eq = 1'b0;
    end else begin
      res_o.gt = ~carry_i.eq & ~carry_i.lt;
      res_o.lt = ~carry_i.eq & ~carry_i.gt;
      res_o.eq = carry_i.eq;
    end
  end
endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
  import cmp_pkg::*;
(
  input  logic [NIB_W-1:0] a_i,
  input  logic [NIB_W-1:0] b_i,
  input  cmp_res_t         carry_i,
  output cmp_res_t         res_o
);
  logic differ;
  logic a_above;

  cmp_word_order #(.W(NIB_W)) u_order (
    .a_i       (a_i),
    .b_i       (b_i),
    .differ_o  (differ),
    .a_above_o (a_above)
  );

  cmp_cascade_merge u_merge (
    .differ_i  (differ),
    .a_above_i (a_above),
    .carry_i   (carry_i),
    .res_o     (res_o)
  );
endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
  import cmp_pkg::*;
#(
  parameter int SLICES = 4
) (
  input  logic [NIB_W*SLICES-1:0] a_i,
  input  logic [NIB_W*SLICES-1:0] b_i,
  input  logic                    casc_gt_i,
  input  logic                    casc_lt_i,
  input  logic                    casc_eq_i,
  output logic                    gt_o,
  output logic                    lt_o,
  output logic                    eq_o
);
  cmp_res_t link [SLICES+1];

  assign link[0] = '{gt: casc_gt_i, lt: casc_lt_i, eq: casc_eq_i};

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    cmp_slice u_slice (
      .a_i     (a_i[k*NIB_W +: NIB_W]),
      .b_i     (b_i[k*NIB_W +: NIB_W]),
      .carry_i (link[k]),
      .res_o   (link[k+1])
    );
  end

  assign gt_o = link[SLICES].gt;
  assign lt_o = link[SLICES].lt;
  assign eq_o = link[SLICES].eq;
endmodule

// File: rtl/cmp_chain_chk.sv
module cmp_chain_chk #(
  parameter int SLICES = 4
) (
  input logic [4*SLICES-1:0] a_i,
  input logic [4*SLICES-1:0] b_i,
  input logic                casc_gt_i,
  input logic                casc_lt_i,
  input logic                casc_eq_i,
  input logic                gt_o,
  input logic                lt_o,
  input logic                eq_o
);
  localparam bit ODD_LEN = (SLICES % 2) == 1;
  localparam logic [2:0] BOTH_HI_OUT = ODD_LEN ? 3'b000 : 3'b110;
  localparam logic [2:0] BOTH_LO_OUT = ODD_LEN ? 3'b110 : 3'b000;

  always_comb begin
    if (a_i != b_i) begin
      // R1: the decision follows unsigned order of the whole word
      a_r1_word_order: assert #0 (gt_o == (a_i > b_i) && lt_o == (a_i < b_i) && !eq_o)
        else $error("R1 order mismatch");
      // R2: cascade cannot change a decided result; exactly one direction
      a_r2_onehot_dir: assert #0 ($onehot({gt_o, lt_o}) && !eq_o)
        else $error("R2 cascade leaked into decided result");
    end else if (casc_eq_i) begin
      a_r3_eq_dominates: assert #0 ({gt_o, lt_o, eq_o} == 3'b001)
        else $error("R3 equal cascade not dominant");
    end else if (casc_gt_i ^ casc_lt_i) begin
      a_r4_copy_through: assert #0 ({gt_o, lt_o, eq_o} == {casc_gt_i, casc_lt_i, 1'b0})
        else $error("R4 cascade not copied");
    end else if (casc_gt_i) begin
      // R7: the illegal pattern alternates once per slice
      a_r5_both_high: assert #0 ({gt_o, lt_o, eq_o} == BOTH_HI_OUT)
        else $error("R5 both-high cascade result");
    end else begin
      a_r6_all_low: assert #0 ({gt_o, lt_o, eq_o} == BOTH_LO_OUT)
        else $error("R6 all-low cascade result");
    end
  end
endmodule

bind cmp_chain cmp_chain_chk #(.SLICES(SLICES)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .casc_gt_i (casc_gt_i),
  .casc_lt_i (casc_lt_i),
  .casc_eq_i (casc_eq_i),
  .gt_o      (gt_o),
  .lt_o      (lt_o),
  .eq_o      (eq_o)
);

// File: tb/tb_cmp_chain.sv
`timescale 1ns/1ps
module tb_cmp_chain;
  localparam int N = 4;
  localparam int W = 4 * N;

  logic clk;
  logic rst_n;
  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b;
  logic cg, cl, ce;
  logic gt, lt, eq;
  logic [3:0] a1, b1;
  logic cg1, cl1, ce1;
  logic gt1, lt1, eq1;

  int n_vec;
  int n_bad;
  bit done;

  cmp_chain #(.SLICES(N)) dut (
    .a_i(a), .b_i(b), .casc_gt_i(cg), .casc_lt_i(cl), .casc_eq_i(ce),
    .gt_o(gt), .lt_o(lt), .eq_o(eq)
  );

  cmp_chain #(.SLICES(1)) dut_one (
    .a_i(a1), .b_i(b1), .casc_gt_i(cg1), .casc_lt_i(cl1), .casc_eq_i(ce1),
    .gt_o(gt1), .lt_o(lt1), .eq_o(eq1)
  );

  // Expected value of one slice, written from R1..R6.
  function automatic logic [2:0] slice_ref(input logic [3:0] x, input logic [3:0] y,
                                           input logic [2:0] c);
    if (x > y) return 3'b100;
    if (x < y) return 3'b010;
    if (c[0]) return 3'b001;
    case (c[2:1])
      2'b10:   return 3'b100;
      2'b01:   return 3'b010;
      2'b11:   return 3'b000;
      default: return 3'b110;
    endcase
  endfunction

  // R7: series chain, least significant nibble first.
  function automatic logic [2:0] chain_ref(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic [2:0] c);
    logic [2:0] r;
    r = c;
    for (int k = 0; k < N; k++) r = slice_ref(x[4*k +: 4], y[4*k +: 4], r);
    return r;
  endfunction

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got gt/lt/eq=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic run_chain(input string tag, input logic [W-1:0] x, input logic [W-1:0] y,
                           input logic [2:0] c);
    @(posedge clk);
    #2;
    a = x; b = y; {cg, cl, ce} = c;
    #2;
    check(tag, {gt, lt, eq}, chain_ref(x, y, c));
  endtask

  initial begin
    done = 1'b0;
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    rst_n = 1'b0;
    a = '0; b = '0; {cg, cl, ce} = 3'b001;
    a1 = '0; b1 = '0; {cg1, cl1, ce1} = 3'b001;
    repeat (3) @(posedge clk);
    #2;
    // R8/R3: no clock edge needed; idle tie-off reads as equal
    check("R8 idle chain", {gt, lt, eq}, 3'b001);
    check("R8 idle slice", {gt1, lt1, eq1}, 3'b001);
    rst_n = 1'b1;

    // R1..R6: exhaustive single slice sweep
    for (int p = 0; p < 256; p++) begin
      for (int c = 0; c < 8; c++) begin
        @(posedge clk);
        #2;
        a1 = p[7:4]; b1 = p[3:0]; {cg1, cl1, ce1} = c[2:0];
        #2;
        check(p[7:4] != p[3:0] ? "R1/R2 slice sweep" : "R3-R6 slice sweep",
              {gt1, lt1, eq1}, slice_ref(p[7:4], p[3:0], c[2:0]));
      end
    end

    // R3..R6 through the chain: equal words, every cascade pattern (R7 parity)
    for (int c = 0; c < 8; c++) begin
      run_chain("R7 equal words cascade", 16'hA5C3, 16'hA5C3, c[2:0]);
    end
    run_chain("R5 chain both high", 16'h0000, 16'h0000, 3'b110);
    run_chain("R6 chain all low", 16'hFFFF, 16'hFFFF, 3'b000);

    // R1/R2: single nibble differs, MSB vs LSB, every cascade pattern
    for (int k = 0; k < N; k++) begin
      for (int c = 0; c < 8; c++) begin
        run_chain("R2 one nibble high", 16'h3333 | (16'h0004 << (4*k)), 16'h3333, c[2:0]);
        run_chain("R2 one nibble low", 16'h3333, 16'h3333 | (16'h0008 << (4*k)), c[2:0]);
      end
    end
    run_chain("R1 msb only", 16'h8000, 16'h7FFF, 3'b001);
    run_chain("R1 lsb only", 16'h1230, 16'h1231, 3'b001);

    // R7: random wide operands, tied off and with random cascade
    void'($urandom(32'h5EED_C0DE));
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x, y;
      logic [2:0] c;
      x = W'($urandom);
      y = (i % 4 == 0) ? (x ^ (W'(1) << ($urandom % W))) : W'($urandom);
      if (i % 8 == 1) y = x;
      c = (i % 2 == 0) ? 3'b001 : 3'($urandom);
      run_chain("R7 random chain", x, y, c);
      if (c == 3'b001) begin
        check("R7 unsigned tie-off", {gt, lt, eq}, {x > y, x < y, x == y});
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule